// File: doc/BRIEF.md
# Polling Serial Result Reader

This block sits on the host side of a delta-sigma converter whose single output pin does two jobs. While the pin is high, no result is waiting. When the pin goes low, a fresh 24-bit result is ready. After each rising edge of the serial clock the pin carries the next result bit. The reader synchronises the pin and waits for a stable low level. It then drives a serial clock with programmable high and low phase lengths and collects the bits into a word, most significant bit first.

When the read ends, the reader either sends one extra clock pulse, which makes the converter drive the pin high again, or it waits until the pin goes high by itself before it looks for the next low. In both cases one result is never read twice. The whole transfer must fit inside one conversion period of the converter. With the default phase lengths a read takes about 5 µs.

The captured word comes out with a one-cycle valid strobe. There is no ready input and no back-pressure. The converter overwrites an unread result, so stalling would lose data. The consumer must take the word in the strobe cycle or read the held word later. The held word stays unchanged until the next strobe.

Top module: `serial_result_reader`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the serial clock is low, the valid strobe is low and the word output is zero.
- R2: A read starts only when enable is high and the synchronised pin has been low on two consecutive samples. A low level that lasts a single system cycle, or any low level while enable is low, produces no serial clock pulse.
- R3: Every high phase of the serial clock lasts at least HI_CYC system cycles and every low phase inside a read lasts at least LO_CYC cycles. Both default to 10, which is 100 ns at 100 MHz.
- R4: Each bit is sampled in the last system cycle of the high phase, from the synchronised pin. A bit that settles up to 50 ns after the rising edge is therefore captured correctly.
- R5: The first bit received becomes bit 23 of the word and the 24th bit received becomes bit 0.
- R6: The valid strobe is high for exactly one cycle per read, in the cycle where the word output takes the new value. The word output then holds that value until the next strobe.
- R7: With trail_en high, a read consists of 25 serial clock pulses: 24 data pulses and one extra pulse that returns the pin high. Ready detection re-arms after that extra pulse.
- R8: With trail_en low, a read consists of exactly 24 pulses. The reader then waits for a high synchronised pin before it re-arms. A pin left low after the read causes no second read and no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new reads to start; a read already under way always completes |
| trail_en | input | 1 | 1: send the extra 25th pulse after the data bits |
| sdo_i | input | 1 | Converter's shared ready/data pin (asynchronous) |
| sclk_o | output | 1 | Serial clock to the converter |
| word_o | output | 24 | Last captured result, MSB first order restored |
| word_valid_o | output | 1 | One-cycle strobe marking a new word_o |

## Verification
Two functions can land in the same or adjacent cycles:
- the release from waiting for a high pin at the end of a trail-less read;
- the detection of the next ready low.

The bench provokes this by giving the converter model an update gap of only three system cycles between the end of one read and the next low level. The read that follows is judged correct when its word matches and its pulse count is exactly 24. The opposite case, where the pin stays low after the last bit, is judged by the absence of any further strobe or pulse over several read lengths.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL_HI,
    ST_TRAIL_LO,
    ST_WAIT_HI
  } rdr_state_t;
endpackage

// File: rtl/rdr_sync.sv
`timescale 1ns/1ps
module rdr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rdr_shift.sv
`timescale 1ns/1ps
module rdr_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic         last_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic [W-2:0] partial;
  logic [W-1:0] word_q;
  logic         valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      partial <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clear_i) begin
        partial <= '0;
      end else if (shift_i) begin
        partial <= {partial[W-3:0], bit_i};
        if (last_i) begin
          word_q  <= {partial, bit_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R6
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(word_q)); // R6
endmodule

// File: rtl/serial_result_reader.sv
`timescale 1ns/1ps
module serial_result_reader
  import rdr_pkg::*;
#(
  parameter int HI_CYC      = 10,
  parameter int LO_CYC      = 10,
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              trail_en,
  input  logic              sdo_i,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int CNT_W = $clog2(((HI_CYC > LO_CYC) ? HI_CYC : LO_CYC) + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] LO_LAST  = CNT_W'(LO_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [BIT_W-1:0] ALL_BITS = BIT_W'(WORD_W);

  rdr_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitcnt;
  logic             sclk_q;
  logic             pin_s, pin_d;
  logic             rdy, capture, last, start;

  rdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sdo_i), .sync_o(pin_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pin_d <= 1'b1;
    else        pin_d <= pin_s;
  end

  assign rdy     = !pin_s && !pin_d;
  assign start   = (st == ST_IDLE) && enable && rdy;
  assign capture = (st == ST_HIGH) && (cnt == HI_LAST);
  assign last    = capture && (bitcnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bitcnt <= '0;
      sclk_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_HIGH;
          sclk_q <= 1'b1;
          cnt    <= '0;
          bitcnt <= '0;
        end
        ST_HIGH: if (cnt == HI_LAST) begin
          st     <= ST_LOW;
          sclk_q <= 1'b0;
          cnt    <= '0;
          bitcnt <= bitcnt + 1'b1;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (cnt == LO_LAST) begin
          cnt <= '0;
          if (bitcnt != ALL_BITS) begin
            st     <= ST_HIGH;
            sclk_q <= 1'b1;
          end else if (trail_en) begin
            st     <= ST_TRAIL_HI;
            sclk_q <= 1'b1;
          end else begin
            st <= ST_WAIT_HI;
          end
        end else cnt <= cnt + 1'b1;
        ST_TRAIL_HI: if (cnt == HI_LAST) begin
          st     <= ST_TRAIL_LO;
          sclk_q <= 1'b0;
          cnt    <= '0;
        end else cnt <= cnt + 1'b1;
        ST_TRAIL_LO: if (cnt == LO_LAST) begin
          st  <= ST_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        ST_WAIT_HI: if (pin_s) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  rdr_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear_i(start), .shift_i(capture),
    .last_i(last), .bit_i(pin_s), .word_o(word_o), .valid_o(word_valid_o)
  );

  assign sclk_o = sclk_q;

  // Phase-length monitor for the width assertions.
  logic        prev_sclk;
  logic [15:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      run_len   <= '0;
    end else begin
      prev_sclk <= sclk_q;
      if (sclk_q != prev_sclk) run_len <= 16'd1;
      else if (run_len != '1)  run_len <= run_len + 1'b1;
    end
  end

  AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !(enable && rdy)) |=> !sclk_q); // R2
  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_q && prev_sclk) |-> (run_len >= 16'(HI_CYC))); // R3
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && !prev_sclk && bitcnt != '0) |-> (run_len >= 16'(LO_CYC))); // R3
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= ALL_BITS); // R5
  AST_NO_TRAIL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW && cnt == LO_LAST && bitcnt == ALL_BITS && !trail_en) |=> !sclk_q); // R8
endmodule

// File: tb/serial_result_reader_tb.sv
`timescale 1ns/1ps
module serial_result_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        trail_en = 1'b1;
  logic        pin = 1'b1;
  logic        sclk;
  logic [23:0] word;
  logic        valid;

  int nchk = 0;
  int nfail = 0;

  // Converter model state.
  logic [23:0] cw = '0;
  int idx = 0;
  int nrise = 0;

  // Phase-width measurement.
  int run = 0;
  int min_hi = 1000000;
  int min_lo = 1000000;
  logic last_s = 1'b0;

  always #5 clk = ~clk;

  serial_result_reader u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trail_en(trail_en),
    .sdo_i(pin), .sclk_o(sclk), .word_o(word), .word_valid_o(valid)
  );

  // Each rising edge drives the next bit 30 ns later; past bit 0 the pin goes high.
  always @(posedge sclk) begin
    if (idx < 24) pin <= #30 cw[23 - idx];
    else          pin <= #30 1'b1;
    idx = idx + 1;
    nrise = nrise + 1;
  end

  always @(negedge clk) begin
    if (sclk === last_s) run = run + 1;
    else begin
      if (last_s && run < min_hi) min_hi = run;
      if (!last_s && run < min_lo) min_lo = run;
      run = 1;
      last_s = sclk;
    end
  end

  localparam logic [24:0] VEC [6] = '{
    {1'b1, 24'hA5C3F1}, {1'b0, 24'h123457}, {1'b1, 24'h800000},
    {1'b0, 24'hFFFFFF}, {1'b1, 24'h000001}, {1'b0, 24'h5A5A5B}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [23:0] w, input int gap);
    pin = 1'b1;
    repeat (gap) @(negedge clk);
    cw = w;
    idx = 0;
    nrise = 0;
    pin = 1'b0;
  endtask

  task automatic wait_valid(output bit seen);
    int t = 0;
    while (valid !== 1'b1 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    seen = (valid === 1'b1);
  endtask

  task automatic do_read(input logic [23:0] w, input logic tr, input int gap,
                         input string req);
    bit seen;
    trail_en = tr;
    present(w, gap);
    wait_valid(seen);
    chk(seen, req, 32'(seen), 32'd1);
    chk(word === w, req, 32'(word), 32'(w));
    @(negedge clk);
    chk(valid === 1'b0, "R6", 32'(valid), 32'd0);
    repeat (40) @(negedge clk);
    chk(nrise == (tr ? 25 : 24), tr ? "R7" : "R8", 32'(nrise), tr ? 32'd25 : 32'd24);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    bit seen;
    int cnt;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sclk === 1'b0, "R1", 32'(sclk), 32'd0);
    chk(valid === 1'b0, "R1", 32'(valid), 32'd0);
    chk(word === 24'h0, "R1", 32'(word), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b0 && valid === 1'b0, "R1", {30'd0, sclk, valid}, 32'd0);

    // R2: enable low blocks a read; raising it starts one
    present(24'h6B1D29, 5);
    repeat (300) @(negedge clk);
    chk(nrise == 0, "R2", 32'(nrise), 32'd0);
    enable = 1'b1;
    wait_valid(seen);
    chk(seen && word === 24'h6B1D29, "R2", 32'(word), 32'h6B1D29);
    repeat (40) @(negedge clk);

    // Table walk: R4, R5, R6, R7, R8
    for (int i = 0; i < 6; i++) begin
      do_read(VEC[i][23:0], VEC[i][24], 5, "R5");
    end

    // R2: one-cycle low glitch on the pin is not a ready level
    trail_en = 1'b1;
    pin = 1'b1;
    repeat (10) @(negedge clk);
    nrise = 0;
    pin = 1'b0;
    @(negedge clk);
    pin = 1'b1;
    repeat (50) @(negedge clk);
    chk(nrise == 0, "R2", 32'(nrise), 32'd0);

    // R8: pin left low after a trail-less read must not start another read
    do_read(24'hC0FFE0, 1'b0, 5, "R4");
    cnt = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (valid === 1'b1) cnt++;
    end
    chk(cnt == 0, "R8", 32'(cnt), 32'd0);
    chk(nrise == 24, "R8", 32'(nrise), 32'd24);
    chk(word === 24'hC0FFE0, "R6", 32'(word), 32'hC0FFE0);

    // R8: short high gap re-arms and the next read is intact
    do_read(24'h3C3C3D, 1'b0, 3, "R8");

    // R3: measured phase widths
    chk(min_hi >= 10, "R3", 32'(min_hi), 32'd10);
    chk(min_lo >= 10, "R3", 32'(min_lo), 32'd10);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule